// File: doc/BRIEF.md
# SHA-512 Acceleration Instruction Unit

This block executes the four SHA-512 helper operations on 128-bit vector values. Each value is treated as two 64-bit lanes: the low lane is bits 63:0 and the high lane is bits 127:64. The caller presents an instruction word, the current destination value (which also acts as an accumulator), up to two source values and a feature-enable bit. The block decodes the word, computes the new destination and registers it together with an illegal-operation flag. The result appears one clock after the issue.

The decoder is combinational and also returns the three 5-bit register indices, so a surrounding register file can fetch operands in the issue cycle. In the two hash operations the high lane is computed first, and its updated value feeds the low-lane computation. All lane arithmetic wraps modulo 2^64.

A two-state machine tracks the output. `ST_IDLE` means no result is presented. `ST_HOLD` means a result is presented on `res_d`/`res_illegal` with `res_valid` high. The transition issue (from either state, when `issue_valid` is high) goes to `ST_HOLD`. The transition drain (from either state, when `issue_valid` is low) goes to `ST_IDLE`. Reset enters `ST_IDLE`.

Top module: `sha512x_exec`

## Requirements
- R1: Hash-part-1 (three-register group, opcode 0). The new high lane is hi1 = d_hi + Σ1(m_hi) + Ch(m_hi, n_lo, n_hi). With u = hi1 + m_lo, the new low lane is d_lo + Σ1(u) + Ch(u, m_hi, n_lo). The functions are defined as follows:
  - Σ1 is ror14 ^ ror18 ^ ror41.
  - Ch(x,y,z) = (x&y)|(~x&z).
  - Sums wrap modulo 2^64.
- R2: Hash-part-2 (three-register group, opcode 1). The new high lane is hi2 = d_hi + Σ0(m_lo) + Maj(n_lo, m_hi, m_lo). The new low lane is d_lo + Σ0(hi2) + Maj(hi2, m_lo, m_hi). The functions are defined as follows:
  - Σ0 is ror28 ^ ror34 ^ ror39.
  - Maj is the bitwise majority.
- R3: Schedule-update-0 (two-register group, opcode 0). The new low lane is d_lo + σ0(d_hi) and the new high lane is d_hi + σ0(n_lo), where σ0 is ror1 ^ ror8 ^ (x>>7). Both lanes use the original d_hi, and m is ignored.
- R4: Schedule-update-1 (three-register group, opcode 2). Each lane L becomes d_L + σ1(n_L) + m_L, where σ1 is ror19 ^ ror61 ^ (x>>6).
- R5: The three-register group is the set of words with (insn & 0xFFE0B000) == 0xCE608000. Such a word is legal only with bit 14 = 0 and bits 11:10 in {0,1,2}. Opcode 3, or bit 14 = 1, is illegal.
- R6: The two-register group is the set of words with (insn & 0xFFFFF000) == 0xCEC08000. Such a word is legal only with bits 11:10 = 0. Any other opcode is illegal.
- R7: `dec_rd` = insn[4:0], `dec_rn` = insn[9:5] and `dec_rm` = insn[20:16], combinationally, for any word.
- R8: When `feature_en` is low at issue, the result is flagged illegal whatever the word.
- R9: An illegal result, including any word outside both groups, returns `res_d` equal to the `d_in` presented at issue.
- R10: `res_valid` is high exactly in the cycle after an issue cycle. After reset, `res_valid`, `res_d` and `res_illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Operation presented this cycle |
| feature_en | input | 1 | SHA-512 operations permitted |
| insn | input | 32 | Instruction word |
| d_in | input | 128 | Destination / accumulator value |
| n_in | input | 128 | First source value |
| m_in | input | 128 | Second source value |
| dec_rd | output | 5 | Destination register index |
| dec_rn | output | 5 | First source register index |
| dec_rm | output | 5 | Second source register index |
| res_valid | output | 1 | Result presented |
| res_d | output | 128 | New destination value |
| res_illegal | output | 1 | Operation was illegal or disabled |

## Verification
The assertions assume that `d_in` and `feature_en` are meaningful only in cycles where `issue_valid` is high, and that the result is consumed in the cycle right after. The directed stimulus follows this: it changes every input at the falling edge, holds it stable across one rising edge, and drops `issue_valid` before the result is sampled. Illegal-word and disabled cases are each issued with a distinctive `d_in`. This lets the pass-through check tell a held value apart from a computed one.

// File: rtl/sha512x_pkg.sv
package sha512x_pkg;
    localparam int LANE_W  = 64;
    localparam int VEC_W   = 2 * LANE_W;
    localparam int INSN_W  = 32;
    localparam int IDX_W   = 5;

    localparam logic [INSN_W-1:0] GRP3_MASK  = 32'hFFE0_B000;
    localparam logic [INSN_W-1:0] GRP3_MATCH = 32'hCE60_8000;
    localparam logic [INSN_W-1:0] GRP2_MASK  = 32'hFFFF_F000;
    localparam logic [INSN_W-1:0] GRP2_MATCH = 32'hCEC0_8000;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_HSH1 = 3'd1,
        OP_HSH2 = 3'd2,
        OP_SCH0 = 3'd3,
        OP_SCH1 = 3'd4
    } sha_op_e;

    typedef logic [LANE_W-1:0] lane_t;

    function automatic lane_t rotr(input lane_t x, input int sh);
        return (x >> sh) | (x << (LANE_W - sh));
    endfunction

    function automatic lane_t big_sig0(input lane_t x);
        return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
    endfunction

    function automatic lane_t big_sig1(input lane_t x);
        return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
    endfunction

    function automatic lane_t sml_sig0(input lane_t x);
        return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
    endfunction

    function automatic lane_t sml_sig1(input lane_t x);
        return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
    endfunction

    function automatic lane_t pick(input lane_t x, input lane_t y, input lane_t z);
        return (x & (y ^ z)) ^ z;
    endfunction

    function automatic lane_t vote(input lane_t x, input lane_t y, input lane_t z);
        return (x & y) | ((x | y) & z);
    endfunction
endpackage

// File: rtl/sha512x_decode.sv
module sha512x_decode
    import sha512x_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output sha_op_e           op,
    output logic [IDX_W-1:0]  rd,
    output logic [IDX_W-1:0]  rn,
    output logic [IDX_W-1:0]  rm
);
    logic in_grp3;
    logic in_grp2;

    assign in_grp3 = (insn & GRP3_MASK) == GRP3_MATCH;
    assign in_grp2 = (insn & GRP2_MASK) == GRP2_MATCH;

    assign rd = insn[4:0];
    assign rn = insn[9:5];
    assign rm = insn[20:16];

    always_comb begin
        op = OP_NONE;
        if (in_grp3 && !insn[14]) begin
            unique case (insn[11:10])
                2'd0:    op = OP_HSH1;
                2'd1:    op = OP_HSH2;
                2'd2:    op = OP_SCH1;
                default: op = OP_NONE;
            endcase
        end else if (in_grp2 && insn[11:10] == 2'd0) begin
            op = OP_SCH0;
        end
    end

    always_comb begin
        assert_groups_disjoint_R5: assert (!(in_grp3 && in_grp2));
    end
endmodule

// File: rtl/sha512x_lanes.sv
module sha512x_lanes
    import sha512x_pkg::*;
(
    input  sha_op_e          op,
    input  logic [VEC_W-1:0] d,
    input  logic [VEC_W-1:0] n,
    input  logic [VEC_W-1:0] m,
    output logic [VEC_W-1:0] d_new
);
    localparam int NLANE = VEC_W / LANE_W;

    lane_t d_lo, d_hi, n_lo, n_hi, m_lo, m_hi;
    lane_t h1_hi, h1_mix, h1_lo;
    lane_t h2_hi, h2_lo;
    lane_t s0_lo, s0_hi;
    logic [VEC_W-1:0] s1_vec;

    assign d_lo = d[LANE_W-1:0];
    assign d_hi = d[VEC_W-1:LANE_W];
    assign n_lo = n[LANE_W-1:0];
    assign n_hi = n[VEC_W-1:LANE_W];
    assign m_lo = m[LANE_W-1:0];
    assign m_hi = m[VEC_W-1:LANE_W];

    // hash part 1: high lane first, its result chained into the low lane
    assign h1_hi  = d_hi + big_sig1(m_hi) + pick(m_hi, n_lo, n_hi);
    assign h1_mix = h1_hi + m_lo;
    assign h1_lo  = d_lo + big_sig1(h1_mix) + pick(h1_mix, m_hi, n_lo);

    // hash part 2: same chaining
    assign h2_hi = d_hi + big_sig0(m_lo) + vote(n_lo, m_hi, m_lo);
    assign h2_lo = d_lo + big_sig0(h2_hi) + vote(h2_hi, m_lo, m_hi);

    // schedule update 0: both lanes read the original high lane
    assign s0_lo = d_lo + sml_sig0(d_hi);
    assign s0_hi = d_hi + sml_sig0(n_lo);

    // schedule update 1: lanes independent
    for (genvar g = 0; g < NLANE; g++) begin : g_sch1
        assign s1_vec[g*LANE_W +: LANE_W] = d[g*LANE_W +: LANE_W]
                                          + sml_sig1(n[g*LANE_W +: LANE_W])
                                          + m[g*LANE_W +: LANE_W];
    end

    always_comb begin
        unique case (op)
            OP_HSH1: d_new = {h1_hi, h1_lo};
            OP_HSH2: d_new = {h2_hi, h2_lo};
            OP_SCH0: d_new = {s0_hi, s0_lo};
            OP_SCH1: d_new = s1_vec;
            default: d_new = d;
        endcase
    end
endmodule

// File: rtl/sha512x_exec.sv
module sha512x_exec
    import sha512x_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic              feature_en,
    input  logic [31:0]       insn,
    input  logic [127:0]      d_in,
    input  logic [127:0]      n_in,
    input  logic [127:0]      m_in,
    output logic [4:0]        dec_rd,
    output logic [4:0]        dec_rn,
    output logic [4:0]        dec_rm,
    output logic              res_valid,
    output logic [127:0]      res_d,
    output logic              res_illegal
);
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } out_state_e;

    out_state_e       state_q, state_d;
    sha_op_e          dec_op;
    logic [VEC_W-1:0] core_d;
    logic             bad_op;

    sha512x_decode u_dec (
        .insn (insn),
        .op   (dec_op),
        .rd   (dec_rd),
        .rn   (dec_rn),
        .rm   (dec_rm)
    );

    sha512x_lanes u_lanes (
        .op    (dec_op),
        .d     (d_in),
        .n     (n_in),
        .m     (m_in),
        .d_new (core_d)
    );

    assign bad_op = (dec_op == OP_NONE) || !feature_en;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = issue_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = issue_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_d       <= '0;
            res_illegal <= 1'b0;
        end else if (issue_valid) begin
            res_d       <= bad_op ? d_in : core_d;
            res_illegal <= bad_op;
        end
    end

    assign res_valid = (state_q == ST_HOLD);

    assert_issue_gives_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> res_valid);
    assert_idle_gives_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> !res_valid);
    assert_disabled_is_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !feature_en) |=> res_illegal);
    assert_illegal_keeps_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && feature_en && dec_op == OP_NONE) |=> (res_illegal && res_d == $past(d_in)));
endmodule

// File: tb/sha512x_exec_tb.sv
module sha512x_exec_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue_valid = 1'b0;
    logic         feature_en = 1'b1;
    logic [31:0]  insn = '0;
    logic [127:0] d_in = '0, n_in = '0, m_in = '0;
    logic [4:0]   dec_rd, dec_rn, dec_rm;
    logic         res_valid, res_illegal;
    logic [127:0] res_d;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sha512x_exec dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .feature_en(feature_en),
        .insn(insn), .d_in(d_in), .n_in(n_in), .m_in(m_in),
        .dec_rd(dec_rd), .dec_rn(dec_rn), .dec_rm(dec_rm),
        .res_valid(res_valid), .res_d(res_d), .res_illegal(res_illegal)
    );

    // independent reference functions
    function automatic logic [63:0] rr(input logic [63:0] x, input int k);
        logic [127:0] w;
        w = {x, x} >> k;
        return w[63:0];
    endfunction
    function automatic logic [63:0] fS0(input logic [63:0] x); return rr(x,28)^rr(x,34)^rr(x,39); endfunction
    function automatic logic [63:0] fS1(input logic [63:0] x); return rr(x,14)^rr(x,18)^rr(x,41); endfunction
    function automatic logic [63:0] fs0(input logic [63:0] x); return rr(x,1)^rr(x,8)^(x>>7); endfunction
    function automatic logic [63:0] fs1(input logic [63:0] x); return rr(x,19)^rr(x,61)^(x>>6); endfunction
    function automatic logic [63:0] fch(input logic [63:0] x, y, z); return (x & y) | (~x & z); endfunction
    function automatic logic [63:0] fmj(input logic [63:0] x, y, z); return (x&y)^(x&z)^(y&z); endfunction

    function automatic logic [127:0] ref_h1(input logic [127:0] d, n, m);
        logic [63:0] hi, u, lo;
        hi = d[127:64] + fS1(m[127:64]) + fch(m[127:64], n[63:0], n[127:64]);
        u  = hi + m[63:0];
        lo = d[63:0] + fS1(u) + fch(u, m[127:64], n[63:0]);
        return {hi, lo};
    endfunction
    function automatic logic [127:0] ref_h2(input logic [127:0] d, n, m);
        logic [63:0] hi, lo;
        hi = d[127:64] + fS0(m[63:0]) + fmj(n[63:0], m[127:64], m[63:0]);
        lo = d[63:0] + fS0(hi) + fmj(hi, m[63:0], m[127:64]);
        return {hi, lo};
    endfunction
    function automatic logic [127:0] ref_u0(input logic [127:0] d, n);
        return {d[127:64] + fs0(n[63:0]), d[63:0] + fs0(d[127:64])};
    endfunction
    function automatic logic [127:0] ref_u1(input logic [127:0] d, n, m);
        return {d[127:64] + fs1(n[127:64]) + m[127:64], d[63:0] + fs1(n[63:0]) + m[63:0]};
    endfunction

    function automatic logic [31:0] enc3(input logic o, input logic [1:0] opc,
                                         input logic [4:0] rd, rn, rm);
        return 32'hCE60_8000 | ({31'd0, o} << 14) | ({11'd0, rm} << 16)
             | ({30'd0, opc} << 10) | ({27'd0, rn} << 5) | {27'd0, rd};
    endfunction
    function automatic logic [31:0] enc2(input logic [1:0] opc, input logic [4:0] rd, rn);
        return 32'hCEC0_8000 | ({30'd0, opc} << 10) | ({27'd0, rn} << 5) | {27'd0, rd};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one op, check result the cycle after
    task automatic run_op(input string req, input logic fe, input logic [31:0] w,
                          input logic [127:0] d, n, m,
                          input logic [127:0] exp_d, input logic exp_ill);
        @(negedge clk);
        feature_en = fe; insn = w; d_in = d; n_in = n; m_in = m; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        chk({req, " valid"}, {127'd0, res_valid}, 128'd1);
        chk({req, " illegal"}, {127'd0, res_illegal}, {127'd0, exp_ill});
        chk({req, " data"}, res_d, exp_d);
    endtask

    localparam logic [127:0] VD = 128'h6a09e667f3bcc908_bb67ae8584caa73b;
    localparam logic [127:0] VN = 128'h3c6ef372fe94f82b_a54ff53a5f1d36f1;
    localparam logic [127:0] VM = 128'h510e527fade682d1_9b05688c2b3e6c1f;
    localparam logic [127:0] VX = 128'hdeadbeef01234567_89abcdeffedcba98;

    task automatic t_reset_R10();
        chk("R10 reset valid", {127'd0, res_valid}, 128'd0);
        chk("R10 reset data", res_d, 128'd0);
        chk("R10 reset illegal", {127'd0, res_illegal}, 128'd0);
    endtask
    task automatic t_hash1_R1();
        run_op("R1 hash1", 1'b1, enc3(1'b0, 2'd0, 5'd1, 5'd2, 5'd3), VD, VN, VM, ref_h1(VD, VN, VM), 1'b0);
        run_op("R1 hash1 wrap", 1'b1, enc3(1'b0, 2'd0, 5'd31, 5'd0, 5'd7), {128{1'b1}}, {128{1'b1}}, {128{1'b1}},
               ref_h1({128{1'b1}}, {128{1'b1}}, {128{1'b1}}), 1'b0);
    endtask
    task automatic t_hash2_R2();
        run_op("R2 hash2", 1'b1, enc3(1'b0, 2'd1, 5'd4, 5'd5, 5'd6), VD, VN, VM, ref_h2(VD, VN, VM), 1'b0);
        run_op("R2 hash2 b", 1'b1, enc3(1'b0, 2'd1, 5'd0, 5'd0, 5'd0), VN, VM, VD, ref_h2(VN, VM, VD), 1'b0);
    endtask
    task automatic t_upd0_R3();
        run_op("R3 upd0", 1'b1, enc2(2'd0, 5'd9, 5'd10), VD, VN, VM, ref_u0(VD, VN), 1'b0);
        run_op("R3 upd0 m ignored", 1'b1, enc2(2'd0, 5'd9, 5'd10), VD, VN, VX, ref_u0(VD, VN), 1'b0);
    endtask
    task automatic t_upd1_R4();
        run_op("R4 upd1", 1'b1, enc3(1'b0, 2'd2, 5'd11, 5'd12, 5'd13), VD, VN, VM, ref_u1(VD, VN, VM), 1'b0);
    endtask
    task automatic t_grp3_R5();
        run_op("R5 bit14 set", 1'b1, enc3(1'b1, 2'd0, 5'd1, 5'd2, 5'd3), VX, VN, VM, VX, 1'b1);
        run_op("R5 opcode3", 1'b1, enc3(1'b0, 2'd3, 5'd1, 5'd2, 5'd3), VX, VN, VM, VX, 1'b1);
    endtask
    task automatic t_grp2_R6();
        run_op("R6 opcode1", 1'b1, enc2(2'd1, 5'd1, 5'd2), VX, VN, VM, VX, 1'b1);
        run_op("R6 opcode3", 1'b1, enc2(2'd3, 5'd1, 5'd2), VX, VN, VM, VX, 1'b1);
    endtask
    task automatic t_index_R7();
        @(negedge clk);
        insn = enc3(1'b0, 2'd1, 5'd17, 5'd22, 5'd29);
        #1;
        chk("R7 rd", {123'd0, dec_rd}, 128'd17);
        chk("R7 rn", {123'd0, dec_rn}, 128'd22);
        chk("R7 rm", {123'd0, dec_rm}, 128'd29);
    endtask
    task automatic t_disable_R8();
        run_op("R8 disabled hash1", 1'b0, enc3(1'b0, 2'd0, 5'd1, 5'd2, 5'd3), VX, VN, VM, VX, 1'b1);
        run_op("R8 disabled upd0", 1'b0, enc2(2'd0, 5'd1, 5'd2), VD, VN, VM, VD, 1'b1);
    endtask
    task automatic t_unmatched_R9();
        run_op("R9 foreign word", 1'b1, 32'h1E20_1C00, VX, VN, VM, VX, 1'b1);
    endtask
    task automatic t_latency_R10();
        run_op("R10 single", 1'b1, enc3(1'b0, 2'd2, 5'd1, 5'd2, 5'd3), VN, VM, VD, ref_u1(VN, VM, VD), 1'b0);
        @(negedge clk);
        chk("R10 valid drops", {127'd0, res_valid}, 128'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_R10();
        rst_n = 1'b1;
        @(negedge clk);
        t_hash1_R1();
        t_hash2_R2();
        t_upd0_R3();
        t_upd1_R4();
        t_grp3_R5();
        t_grp2_R6();
        t_index_R7();
        t_disable_R8();
        t_unmatched_R9();
        t_latency_R10();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule